// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block drives the clock-enable of each rank behind a DDR-style memory controller. Each rank has its own idle timer, which any command to that rank clears. When the timer reaches a programmable threshold and nothing blocks entry, the rank's clock enable drops. The block also records which power-down flavour the rank entered. If every page of the rank is closed at that moment, the rank is in precharge power-down. If any page is still open, it is in active power-down. A request aimed at a sleeping rank wakes it. The clock enable is held low for a minimum time first. After it rises, the rank stays not-ready to the scheduler for a programmable exit latency.

Software programs one cumulative upper boundary per rank. A rank whose boundary does not exceed the boundary of the rank below it holds no memory. Once software sets the tri-state enable, the chip-select and clock-enable output enables of such ranks are dropped. Until then, every rank is treated as populated and driven, which matches the state out of reset.

Top module: `rank_pd_ctrl`

## Requirements
- R1: During and right after a synchronous reset, every rank is active: clock enable high, both output enables high, ready high, and state code 00.
- R2: A rank's idle count restarts on each cycle with its command strobe. If no command, refresh or request follows, the clock enable falls at the (T+1)-th rising edge after the edge that sampled the last command, where T is the idle threshold.
- R3: The state field is 2 bits per rank, at bits [2i+1:2i]. Its codes are 00 active or waking, 01 precharge power-down, 10 active power-down and 11 disabled. A rank enters 01 if its page-open input is low in the entry cycle, and 10 if that input is high.
- R4: An idle threshold of zero keeps every active rank out of power-down, however long it stays idle.
- R5: Power-down entry is blocked in any cycle where the rank's refresh-busy input or its request input is high.
- R6: Once a rank's clock enable falls for power-down, it stays low for at least max(M,1) cycles, where M is the minimum low time. With a request held from entry onward, it rises exactly max(M,1) cycles after falling.
- R7: After the clock enable rises on wake-up, the ready output rises exactly max(L,1) cycles later, where L is the exit latency. The state code reads 00 while the rank is waking.
- R8: Rank i is unpopulated when its boundary field, bits [i*BND_W +: BND_W] of the boundary bus, is less than or equal to the field of rank i-1. For rank 0 this means a field equal to zero.
- R9: With the tri-state enable set, an unpopulated rank has both output enables low, clock enable low, ready low and state code 11, one edge after the condition holds. Populated ranks stay driven, and with the enable clear every rank is driven. When the condition clears, the rank returns to active one edge later.
- R10: A rank whose clock enable is low never reports ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NUM_RANKS | Command issued to each rank this cycle |
| req_pending | input | NUM_RANKS | Scheduler has work queued for each rank |
| pages_open | input | NUM_RANKS | Any bank page open in each rank |
| refresh_busy | input | NUM_RANKS | Refresh pending or running on each rank |
| idle_thresh | input | CNT_W | Idle cycles before power-down, 0 disables |
| min_low | input | CNT_W | Minimum clock-enable low time in cycles |
| exit_lat | input | CNT_W | Cycles from clock-enable rise to ready |
| rank_bound | input | NUM_RANKS*BND_W | Cumulative upper boundary per rank |
| tristate_en | input | 1 | Allow tri-stating of unpopulated ranks |
| cke | output | NUM_RANKS | Clock enable per rank |
| cke_oe | output | NUM_RANKS | Clock-enable output enable per rank |
| cs_oe | output | NUM_RANKS | Chip-select output enable per rank |
| rank_ready | output | NUM_RANKS | Rank accepts commands |
| rank_state | output | 2*NUM_RANKS | Per-rank state code |

## Verification
Each rank keeps one state register and one shared timer. A wrong timer value shows at the ports as a clock-enable or ready edge that comes one or more cycles early or late, on the very transition that uses it. A wrong state register shows at once as a mismatched state code, an output enable that drops on a populated rank, or ready asserted with clock enable low. The bench runs a reference model in step with the design and compares every rank output on every cycle. A fault is therefore caught in the first cycle it reaches a port.

// File: rtl/rank_pd_pkg.sv
package rank_pd_pkg;
  typedef enum logic [2:0] {
    RK_ACT  = 3'd0,
    RK_PPD  = 3'd1,
    RK_APD  = 3'd2,
    RK_WAKE = 3'd3,
    RK_OFF  = 3'd4
  } rk_state_e;

  localparam logic [1:0] CODE_ACTIVE = 2'b00;
  localparam logic [1:0] CODE_PRE_PD = 2'b01;
  localparam logic [1:0] CODE_ACT_PD = 2'b10;
  localparam logic [1:0] CODE_OFF    = 2'b11;

  function automatic logic [1:0] rk_code(rk_state_e s);
    case (s)
      RK_PPD:  return CODE_PRE_PD;
      RK_APD:  return CODE_ACT_PD;
      RK_OFF:  return CODE_OFF;
      default: return CODE_ACTIVE;
    endcase
  endfunction
endpackage

// File: rtl/rank_pop_decode.sv
module rank_pop_decode #(
  parameter int NUM_RANKS = 4,
  parameter int BND_W     = 8
) (
  input  logic [NUM_RANKS*BND_W-1:0] bounds,
  output logic [NUM_RANKS-1:0]       empty
);
  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
    if (i == 0) begin : g_first
      assign empty[i] = (bounds[0 +: BND_W] == '0);
    end else begin : g_rest
      assign empty[i] = (bounds[i*BND_W +: BND_W] <= bounds[(i-1)*BND_W +: BND_W]);
    end
  end
endmodule

// File: rtl/rank_pd_fsm.sv
module rank_pd_fsm
  import rank_pd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic             req,
  input  logic             page_open,
  input  logic             refresh,
  input  logic             empty,
  input  logic             off_en,
  input  logic [CNT_W-1:0] idle_thresh,
  input  logic [CNT_W-1:0] min_low,
  input  logic [CNT_W-1:0] exit_lat,
  output logic             cke,
  output logic             oe,
  output logic             ready,
  output logic [1:0]       code
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  rk_state_e        st;
  logic [CNT_W-1:0] tmr;   // idle count, low time or wake time, by state
  logic             go_down;

  assign go_down = (idle_thresh != '0) && (tmr >= idle_thresh) &&
                   !cmd && !refresh && !req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RK_ACT;
      tmr <= '0;
    end else if (off_en && empty) begin
      st  <= RK_OFF;
      tmr <= '0;
    end else begin
      case (st)
        RK_ACT: begin
          if (cmd) begin
            tmr <= '0;
          end else if (go_down) begin
            st  <= page_open ? RK_APD : RK_PPD;
            tmr <= ONE;
          end else if (tmr < idle_thresh) begin
            tmr <= tmr + ONE;
          end
        end
        RK_PPD, RK_APD: begin
          if (req && tmr >= min_low) begin
            st  <= RK_WAKE;
            tmr <= ONE;
          end else if (tmr < min_low) begin
            tmr <= tmr + ONE;
          end
        end
        RK_WAKE: begin
          if (tmr >= exit_lat) begin
            st  <= RK_ACT;
            tmr <= '0;
          end else begin
            tmr <= tmr + ONE;
          end
        end
        default: begin
          st  <= RK_ACT;
          tmr <= '0;
        end
      endcase
    end
  end

  assign cke   = !(st == RK_PPD || st == RK_APD || st == RK_OFF);
  assign oe    = (st != RK_OFF);
  assign ready = (st == RK_ACT);
  assign code  = rk_code(st);
endmodule

// File: rtl/rank_pd_ctrl.sv
module rank_pd_ctrl #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 8,
  parameter int BND_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_RANKS-1:0]       cmd_valid,
  input  logic [NUM_RANKS-1:0]       req_pending,
  input  logic [NUM_RANKS-1:0]       pages_open,
  input  logic [NUM_RANKS-1:0]       refresh_busy,
  input  logic [CNT_W-1:0]           idle_thresh,
  input  logic [CNT_W-1:0]           min_low,
  input  logic [CNT_W-1:0]           exit_lat,
  input  logic [NUM_RANKS*BND_W-1:0] rank_bound,
  input  logic                       tristate_en,
  output logic [NUM_RANKS-1:0]       cke,
  output logic [NUM_RANKS-1:0]       cke_oe,
  output logic [NUM_RANKS-1:0]       cs_oe,
  output logic [NUM_RANKS-1:0]       rank_ready,
  output logic [2*NUM_RANKS-1:0]     rank_state
);
  logic [NUM_RANKS-1:0] empty;
  logic [NUM_RANKS-1:0] drive;

  rank_pop_decode #(.NUM_RANKS(NUM_RANKS), .BND_W(BND_W)) u_pop (
    .bounds (rank_bound),
    .empty  (empty)
  );

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
    rank_pd_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .cmd         (cmd_valid[i]),
      .req         (req_pending[i]),
      .page_open   (pages_open[i]),
      .refresh     (refresh_busy[i]),
      .empty       (empty[i]),
      .off_en      (tristate_en),
      .idle_thresh (idle_thresh),
      .min_low     (min_low),
      .exit_lat    (exit_lat),
      .cke         (cke[i]),
      .oe          (drive[i]),
      .ready       (rank_ready[i]),
      .code        (rank_state[2*i +: 2])
    );
  end

  assign cke_oe = drive;
  assign cs_oe  = drive;
endmodule

// File: rtl/rank_pd_ctrl_chk.sv
module rank_pd_ctrl_chk #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 8,
  parameter int BND_W     = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_RANKS-1:0]       pages_open,
  input logic [NUM_RANKS-1:0]       refresh_busy,
  input logic [CNT_W-1:0]           idle_thresh,
  input logic [CNT_W-1:0]           min_low,
  input logic [NUM_RANKS*BND_W-1:0] rank_bound,
  input logic                       tristate_en,
  input logic [NUM_RANKS-1:0]       cke,
  input logic [NUM_RANKS-1:0]       cke_oe,
  input logic [NUM_RANKS-1:0]       cs_oe,
  input logic [NUM_RANKS-1:0]       rank_ready,
  input logic [2*NUM_RANKS-1:0]     rank_state
);
  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
    logic        hollow;
    logic [15:0] low_run;
    logic [1:0]  cd;
    logic        pd_now;

    if (i == 0) begin : g_first
      assign hollow = (rank_bound[0 +: BND_W] == '0);
    end else begin : g_rest
      assign hollow = (rank_bound[i*BND_W +: BND_W] <= rank_bound[(i-1)*BND_W +: BND_W]);
    end

    assign cd     = rank_state[2*i +: 2];
    assign pd_now = (cd == 2'b01) || (cd == 2'b10);

    always_ff @(posedge clk) begin
      if (rst)              low_run <= '0;
      else if (cke[i])      low_run <= '0;
      else if (~&low_run)   low_run <= low_run + 16'd1;
    end

    AST_PRE_PD_CLOSED: assert property (@(posedge clk) disable iff (rst)
      (cd == 2'b01 && $past(cd) == 2'b00) |-> !$past(pages_open[i])); // R3
    AST_ACT_PD_OPEN: assert property (@(posedge clk) disable iff (rst)
      (cd == 2'b10 && $past(cd) == 2'b00) |-> $past(pages_open[i])); // R3
    AST_NO_ENTRY_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
      ($fell(cke[i]) && pd_now) |-> !$past(refresh_busy[i])); // R5
    AST_ZERO_THRESH_STAYS: assert property (@(posedge clk) disable iff (rst)
      ($fell(cke[i]) && pd_now) |-> ($past(idle_thresh) != '0)); // R4
    AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
      rank_ready[i] |-> cke[i]); // R10
    AST_OE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
      !cs_oe[i] |-> ($past(tristate_en) && $past(hollow))); // R9
    AST_OE_PAIR: assert property (@(posedge clk) disable iff (rst)
      cs_oe[i] == cke_oe[i]); // R9
    AST_MIN_LOW_TIME: assert property (@(posedge clk) disable iff (rst)
      ($rose(cke[i]) && ($past(cd) == 2'b01 || $past(cd) == 2'b10))
        |-> (low_run >= 16'(min_low))); // R6
  end
endmodule

bind rank_pd_ctrl rank_pd_ctrl_chk #(
  .NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W), .BND_W(BND_W)
) u_chk (.*);

// File: tb/rank_pd_ctrl_test.sv
module rank_pd_ctrl_test;
  localparam int NR = 4;
  localparam int CW = 8;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NR-1:0] cmd_valid, req_pending, pages_open, refresh_busy;
  logic [CW-1:0] idle_thresh, min_low, exit_lat;
  logic [BW-1:0] bnd [NR];
  logic [NR*BW-1:0] rank_bound;
  logic          tristate_en;
  logic [NR-1:0] cke, cke_oe, cs_oe, rank_ready;
  logic [2*NR-1:0] rank_state;

  int tests = 0;
  int fails = 0;
  bit started = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NR; g++) begin : g_bnd
    assign rank_bound[g*BW +: BW] = bnd[g];
  end

  rank_pd_ctrl #(.NUM_RANKS(NR), .CNT_W(CW), .BND_W(BW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .req_pending(req_pending),
    .pages_open(pages_open), .refresh_busy(refresh_busy),
    .idle_thresh(idle_thresh), .min_low(min_low), .exit_lat(exit_lat),
    .rank_bound(rank_bound), .tristate_en(tristate_en),
    .cke(cke), .cke_oe(cke_oe), .cs_oe(cs_oe), .rank_ready(rank_ready),
    .rank_state(rank_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: mode 0 active, 1 precharge pd, 2 active pd, 3 off, 4 waking
  int mode [NR];
  int cnt  [NR];

  function automatic bit hollow(int i);
    if (i == 0) return bnd[0] == 0;
    return bnd[i] <= bnd[i-1];
  endfunction

  always @(posedge clk) begin
    started = 1;
    for (int i = 0; i < NR; i++) begin
      if (rst) begin
        mode[i] = 0; cnt[i] = 0;
      end else if (tristate_en && hollow(i)) begin
        mode[i] = 3; cnt[i] = 0;
      end else if (mode[i] == 3) begin
        mode[i] = 0; cnt[i] = 0;
      end else if (mode[i] == 0) begin
        if (cmd_valid[i]) cnt[i] = 0;
        else if (idle_thresh != 0 && cnt[i] >= int'(idle_thresh) &&
                 !refresh_busy[i] && !req_pending[i]) begin
          mode[i] = pages_open[i] ? 2 : 1; cnt[i] = 1;
        end else if (cnt[i] < int'(idle_thresh)) cnt[i]++;
      end else if (mode[i] == 1 || mode[i] == 2) begin
        if (req_pending[i] && cnt[i] >= int'(min_low)) begin
          mode[i] = 4; cnt[i] = 1;
        end else if (cnt[i] < int'(min_low)) cnt[i]++;
      end else begin
        if (cnt[i] >= int'(exit_lat)) begin mode[i] = 0; cnt[i] = 0; end
        else cnt[i]++;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < NR; i++) begin
        chk("R6 model cke", int'(cke[i]), (mode[i] == 1 || mode[i] == 2 || mode[i] == 3) ? 0 : 1);
        chk("R9 model oe", int'(cs_oe[i]), (mode[i] == 3) ? 0 : 1);
        chk("R7 model ready", int'(rank_ready[i]), (mode[i] == 0) ? 1 : 0);
        chk("R3 model state", int'(rank_state[2*i +: 2]), (mode[i] == 4) ? 0 : mode[i]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1;
    cmd_valid = 4'b1110; req_pending = '0; pages_open = 4'b0010; refresh_busy = '0;
    idle_thresh = 8'd5; min_low = 8'd3; exit_lat = 8'd4; tristate_en = 1'b0;
    bnd[0] = 8'd16; bnd[1] = 8'd32; bnd[2] = 8'd48; bnd[3] = 8'd64;
    repeat (3) @(negedge clk);
    chk("R1 cke", int'(cke), 15);
    chk("R1 oe", int'(cs_oe & cke_oe), 15);
    chk("R1 ready", int'(rank_ready), 15);
    chk("R1 state", int'(rank_state), 0);
    rst = 1'b0;
    cmd_valid[0] = 1'b1;
    @(negedge clk);
    cmd_valid[0] = 1'b0;
    n = 0;
    while (cke[0] && n < 100) begin @(negedge clk); n++; end
    chk("R2 idle edges to entry", n, 6);
    chk("R3 closed pages gives 01", int'(rank_state[1:0]), 1);
    chk("R10 ready low in pd", int'(rank_ready[0]), 0);

    req_pending[0] = 1'b1;
    n = 0;
    while (!cke[0] && n < 100) begin @(negedge clk); n++; end
    chk("R6 low time", n, 3);
    chk("R7 state while waking", int'(rank_state[1:0]), 0);
    chk("R7 not ready while waking", int'(rank_ready[0]), 0);
    n = 0;
    while (!rank_ready[0] && n < 100) begin @(negedge clk); n++; end
    chk("R7 exit latency", n, 4);
    req_pending[0] = 1'b0;

    cmd_valid[1] = 1'b0;
    n = 0;
    while (cke[1] && n < 100) begin @(negedge clk); n++; end
    chk("R3 open page gives 10", int'(rank_state[3:2]), 2);

    idle_thresh = 8'd0;
    cmd_valid[2] = 1'b0;
    repeat (40) @(negedge clk);
    chk("R4 zero threshold holds cke", int'(cke[2]), 1);

    idle_thresh = 8'd5;
    refresh_busy[3] = 1'b1;
    cmd_valid[3] = 1'b0;
    req_pending[2] = 1'b1;
    repeat (30) @(negedge clk);
    chk("R5 refresh blocks entry", int'(cke[3]), 1);
    chk("R5 request blocks entry", int'(cke[2]), 1);
    refresh_busy[3] = 1'b0;
    req_pending[2] = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 entry after refresh", int'(cke[3]), 0);

    bnd[0] = 8'd0; bnd[3] = 8'd48;
    repeat (3) @(negedge clk);
    chk("R9 driven before enable", int'(cs_oe), 15);
    tristate_en = 1'b1;
    @(negedge clk);
    chk("R8 cs enable mask", int'(cs_oe), 6);
    chk("R8 cke enable mask", int'(cke_oe), 6);
    chk("R9 rank3 state off", int'(rank_state[7:6]), 3);
    chk("R9 rank0 state off", int'(rank_state[1:0]), 3);
    chk("R9 rank3 not ready", int'(rank_ready[3]), 0);
    tristate_en = 1'b0;
    @(negedge clk);
    chk("R9 all driven after clear", int'(cs_oe), 15);
    chk("R9 rank0 back to active", int'(rank_state[1:0]), 0);
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule